// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a 16-bit virtual address into a 15-bit physical address by looking up a 16-entry page map held in flip-flops. Memory is split into 4096-byte units on both sides. The upper four address bits select one of 16 virtual pages, and the lower twelve bits are the byte offset inside the page. Each map entry stores the number of one of 8 physical frames and a present flag. The physical address is the entry's frame number placed above the unchanged offset.

Software fills and edits the map through a write port. It can install a mapping, move a page to another frame, or mark a page absent. A request presented on one clock edge is answered on the next. A present page returns its physical address. An absent page returns no address. Instead it raises a sticky fault flag and records the faulting page number until software acknowledges the fault. Software then handles eviction and the disk transfer, rewrites the map and retries the access.

Top module: `pgxlat_top`

## Requirements
- R1: The page index is vaddr[15:12]. A request to a present page yields rsp_paddr = frame*4096 + vaddr[11:0]. For example, page 2 mapped to frame 6 turns 8196 into 24580, page 0 mapped to frame 2 turns 1026 into 9218, and page 5 mapped to frame 3 turns 20500 into 12308.
- R2: The response appears in the cycle after the request edge. rsp_valid is 1 only for a request that hit a present page, and it is 0 in any cycle that follows no request.
- R3: The low 12 bits of rsp_paddr always equal the low 12 bits of the requesting address, including offset 0xFFF in page 15.
- R4: A request to an absent page gives rsp_valid=0 and rsp_paddr=0 in the response cycle, and fault_flag becomes 1 in that same cycle.
- R5: fault_page holds the 4-bit page index of the request that raised the fault.
- R6: A map write (map_we=1 with map_page, map_frame, map_present) takes effect from the next cycle. A request in the same cycle as a write to the same entry is translated with the old entry.
- R7: fault_flag stays 1 until fault_ack is sampled high. With no new fault in that cycle, the flag is 0 from the next cycle.
- R8: While fault_flag is 1, further faults leave fault_page unchanged, so the first fault is kept. If fault_ack and a new fault share a cycle, the flag stays 1 and fault_page takes the new page.
- R9: After reset every entry is absent, fault_flag=0 and rsp_valid=0, so any request faults.
- R10: Clearing a page's present flag makes later accesses to it fault. Remapping an absent page makes it translate, for example page 8 moved to frame 1 turns 32780 into 4108.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| map_we | input | 1 | Map write strobe |
| map_page | input | 4 | Page index to write |
| map_frame | input | 3 | Frame number to store |
| map_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Translation produced a physical address |
| rsp_paddr | output | 15 | Physical address, zero when no translation |
| fault_flag | output | 1 | Sticky page-fault indication |
| fault_page | output | 4 | Page index that faulted |
| fault_ack | input | 1 | Software acknowledge, clears the fault flag |

## Verification
The bench targets a write and a lookup to the same entry in one cycle. A design that forwards the new entry would return 28676 where 24580 is expected. It sends a second fault while the first is unacknowledged. A design without the sticky hold would report page 9 instead of page 8. It raises a new fault in the same cycle as the acknowledge. A design with the wrong priority would drop that fault and leave the flag clear. It also checks that a faulting request exposes no address, and that an address at the top of the space keeps offset 0xFFF. A design that leaked the stale frame or truncated the concatenation would show a nonzero or wrong rsp_paddr.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
  localparam int unsigned DEF_VA_W  = 16;
  localparam int unsigned DEF_PA_W  = 15;
  localparam int unsigned DEF_OFF_W = 12;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lk_result_e;
endpackage

// File: rtl/pgxlat_table.sv
module pgxlat_table #(
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned N_PAGES = 1 << PAGE_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PAGE_W-1:0]  wr_page_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic               wr_present_i,
  input  logic [PAGE_W-1:0]  rd_page_i,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic               rd_present_o
);
  logic [N_PAGES-1:0][FRAME_W-1:0] frame_q, frame_d;
  logic [N_PAGES-1:0]              present_q, present_d;
  logic [N_PAGES-1:0]              entry_en;

  for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
    assign entry_en[g] = wr_en_i && (wr_page_i == PAGE_W'(g));

    always_comb begin
      frame_d[g]   = frame_q[g];
      present_d[g] = present_q[g];
      if (entry_en[g]) begin
        frame_d[g]   = wr_frame_i;
        present_d[g] = wr_present_i;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q[g]   <= '0;
        present_q[g] <= 1'b0;
      end else if (entry_en[g]) begin
        frame_q[g]   <= frame_d[g];
        present_q[g] <= present_d[g];
      end
    end
  end

  assign rd_frame_o   = frame_q[rd_page_i];
  assign rd_present_o = present_q[rd_page_i];

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_i |=> (present_q[$past(wr_page_i)] == $past(wr_present_i)) &&
                (frame_q[$past(wr_page_i)] == $past(wr_frame_i)));

  p_untouched_stable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en_i |=> $stable(present_q) && $stable(frame_q));
endmodule

// File: rtl/pgxlat_lookup.sv
module pgxlat_lookup
  import pgxlat_pkg::*;
#(
  parameter int unsigned VA_W    = 16,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned PAGE_W = VA_W - OFF_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  output logic [PAGE_W-1:0]  page_o,
  input  logic [FRAME_W-1:0] ent_frame_i,
  input  logic               ent_present_i,
  output lk_result_e         result_o,
  output logic [PA_W-1:0]    paddr_o
);
  logic [OFF_W-1:0] offset;

  assign page_o = req_vaddr_i[VA_W-1:OFF_W];
  assign offset = req_vaddr_i[OFF_W-1:0];

  always_comb begin
    result_o = LK_IDLE;
    paddr_o  = '0;
    if (req_valid_i) begin
      if (ent_present_i) begin
        result_o = LK_HIT;
        paddr_o  = {ent_frame_i, offset};
      end else begin
        result_o = LK_MISS;
      end
    end
  end
endmodule

// File: rtl/pgxlat_fault.sv
module pgxlat_fault #(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [PAGE_W-1:0] miss_page_i,
  input  logic              ack_i,
  output logic              flag_o,
  output logic [PAGE_W-1:0] page_o
);
  logic              flag_q, flag_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              capture;
  logic              upd_en;

  assign capture = miss_i && (!flag_q || ack_i);
  assign upd_en  = capture || ack_i;

  always_comb begin
    flag_d = flag_q;
    page_d = page_q;
    if (capture) begin
      flag_d = 1'b1;
      page_d = miss_page_i;
    end else if (ack_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      page_q <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      page_q <= page_d;
    end
  end

  assign flag_o = flag_q;
  assign page_o = page_q;

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !miss_i) |=> !flag_q);

  p_first_kept_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> $stable(page_q));

  p_miss_recorded_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (miss_i && !flag_q) |=> flag_q && (page_q == $past(miss_page_i)));
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
  import pgxlat_pkg::*;
#(
  parameter int unsigned VA_W  = DEF_VA_W,
  parameter int unsigned PA_W  = DEF_PA_W,
  parameter int unsigned OFF_W = DEF_OFF_W,
  localparam int unsigned PAGE_W  = VA_W - OFF_W,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_we,
  input  logic [PAGE_W-1:0]  map_page,
  input  logic [FRAME_W-1:0] map_frame,
  input  logic               map_present,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               fault_flag,
  output logic [PAGE_W-1:0]  fault_page,
  input  logic               fault_ack
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PAGE_W-1:0]  lk_page;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_present;
  lk_result_e         lk_result;
  logic [PA_W-1:0]    lk_paddr;
  logic               lk_miss;

  pgxlat_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .wr_en_i      (map_we),
    .wr_page_i    (map_page),
    .wr_frame_i   (map_frame),
    .wr_present_i (map_present),
    .rd_page_i    (lk_page),
    .rd_frame_o   (ent_frame),
    .rd_present_o (ent_present)
  );

  pgxlat_lookup #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_lookup (
    .req_valid_i   (req_valid),
    .req_vaddr_i   (req_vaddr),
    .page_o        (lk_page),
    .ent_frame_i   (ent_frame),
    .ent_present_i (ent_present),
    .result_o      (lk_result),
    .paddr_o       (lk_paddr)
  );

  assign lk_miss = (lk_result == LK_MISS);

  pgxlat_fault #(.PAGE_W(PAGE_W)) u_fault (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .miss_i      (lk_miss),
    .miss_page_i (lk_page),
    .ack_i       (fault_ack),
    .flag_o      (fault_flag),
    .page_o      (fault_page)
  );

  // response stage
  logic            rsp_valid_q, rsp_valid_d;
  logic [PA_W-1:0] rsp_paddr_q, rsp_paddr_d;
  logic            rsp_en;

  assign rsp_en = req_valid || rsp_valid_q;

  always_comb begin
    rsp_valid_d = (lk_result == LK_HIT);
    rsp_paddr_d = rsp_valid_d ? lk_paddr : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else if (rsp_en) begin
      rsp_valid_q <= rsp_valid_d;
      rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_paddr = rsp_paddr_q;

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && ent_present) |=> rsp_valid &&
      (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  p_no_addr_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !ent_present) |=> !rsp_valid && (rsp_paddr == '0) && fault_flag);

  p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/pgxlat_top_bench.sv
module pgxlat_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_we, map_present, req_valid, fault_ack;
  logic [3:0]  map_page;
  logic [2:0]  map_frame;
  logic [15:0] req_vaddr;
  logic        rsp_valid, fault_flag;
  logic [14:0] rsp_paddr;
  logic [3:0]  fault_page;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pgxlat_top u_pgxlat_top (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_page(map_page),
    .map_frame(map_frame), .map_present(map_present), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .fault_flag(fault_flag), .fault_page(fault_page), .fault_ack(fault_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    map_we = 0; map_page = 0; map_frame = 0; map_present = 0;
    req_valid = 0; req_vaddr = 0; fault_ack = 0;
  endtask

  task automatic put_map(input int pg, input int fr, input bit pr);
    @(negedge clk);
    map_we = 1; map_page = 4'(pg); map_frame = 3'(fr); map_present = pr;
    @(posedge clk);
    @(negedge clk);
    map_we = 0;
  endtask

  // request: outputs sampled 1 time unit after the answering edge
  task automatic send(input int va);
    @(negedge clk);
    req_valid = 1; req_vaddr = 16'(va);
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    fault_ack = 1;
    @(posedge clk);
    @(negedge clk);
    fault_ack = 0;
  endtask

  task automatic expect_hit(input string tag, input int va, input int pa);
    send(va);
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " rsp_paddr"}, int'(rsp_paddr), pa);
  endtask

  task automatic t_reset();
    chk("R9 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R9 fault_flag after reset", int'(fault_flag), 0);
    send(16'h1234);
    chk("R9 empty map faults", int'(fault_flag), 1);
    chk("R4 no address on fault", int'(rsp_paddr), 0);
    chk("R5 fault page", int'(fault_page), 1);
    do_ack();
    chk("R7 ack clears", int'(fault_flag), 0);
  endtask

  task automatic t_translate();
    put_map(0, 2, 1); put_map(2, 6, 1); put_map(5, 3, 1); put_map(1, 1, 1);
    expect_hit("R1 1026", 1026, 9218);
    expect_hit("R1 8196", 8196, 24580);
    expect_hit("R1 20500", 20500, 12308);
    expect_hit("R1 0", 0, 8192);
    expect_hit("R1 8192", 8192, 24576);
    expect_hit("R1 4100", 4100, 4100);
    @(negedge clk);
    chk("R2 no request no response", int'(rsp_valid), 0);
    put_map(15, 7, 1);
    expect_hit("R3 top address", 16'hFFFF, 15'h7FFF);
  endtask

  task automatic t_fault_hold();
    send(32780);
    chk("R4 rsp_valid on fault", int'(rsp_valid), 0);
    chk("R4 paddr on fault", int'(rsp_paddr), 0);
    chk("R4 flag", int'(fault_flag), 1);
    chk("R5 page 8", int'(fault_page), 8);
    send(16'h9000);
    chk("R8 first fault kept", int'(fault_page), 8);
    repeat (3) @(negedge clk);
    chk("R7 flag held", int'(fault_flag), 1);
    do_ack();
    chk("R7 cleared", int'(fault_flag), 0);
  endtask

  task automatic t_remap();
    put_map(1, 0, 0);
    put_map(8, 1, 1);
    expect_hit("R10 32780", 32780, 4108);
    send(16'h1004);
    chk("R10 cleared page faults", int'(fault_flag), 1);
    chk("R10 cleared page number", int'(fault_page), 1);
    do_ack();
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    map_we = 1; map_page = 2; map_frame = 7; map_present = 1;
    req_valid = 1; req_vaddr = 16'd8196;
    @(posedge clk); #1;
    chk("R6 old entry used", int'(rsp_paddr), 24580);
    @(negedge clk);
    map_we = 0; req_valid = 0;
    expect_hit("R6 new entry", 8196, 28676);
  endtask

  task automatic t_ack_vs_fault();
    send(16'h9000);
    chk("R5 page 9", int'(fault_page), 9);
    @(negedge clk);
    fault_ack = 1; req_valid = 1; req_vaddr = 16'hA000;
    @(posedge clk); #1;
    chk("R8 flag stays on ack plus fault", int'(fault_flag), 1);
    chk("R8 new page taken", int'(fault_page), 10);
    @(negedge clk);
    fault_ack = 0; req_valid = 0;
    do_ack();
    chk("R7 final clear", int'(fault_flag), 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_translate();
    t_fault_hold();
    t_remap();
    t_same_cycle();
    t_ack_vs_fault();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule